// File: doc/BRIEF.md
# DMA Bus Error Capture Unit

This block sits beside a multi-channel DMA engine that moves data over two buses: a main system bus and a local bus. It watches the completion strobe of every DMA transaction on each bus. When a completed transaction is flagged as failed, the block does four things. It records the faulting address and the channel number in a capture pair kept for that bus. It sets a sticky error event bit and raises an interrupt if the interrupt is enabled. It also asserts a halt line that freezes the whole communications subsystem.

Software handles the fault through a small register port. It reads the capture registers to find the failing address and channel, and it can acknowledge the event bit. The halt, however, is lifted only by a subsystem reset command written to a command register. That command wipes the halt, the event bit and both capture pairs in a single cycle. The capture pairs keep the first fault seen on their own bus, so a burst of later failures cannot hide the original cause.

Top module: `dma_err_capture`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `halt` is 0.
- R2: A bus error event is a cycle with both `*_done` and `*_err` high on that bus. One cycle after an event, status bit 0 (event) and status bit 1 (halt) read 1 and `halt` is 1. A cycle with only one of the two strobes high changes nothing.
- R3: A main-bus error event stores `main_addr` at offset 2 and `main_chan`, zero-extended, at offset 3.
- R4: A local-bus error event stores `loc_addr` at offset 4 and `loc_chan`, zero-extended, at offset 5.
- R5: Each bus keeps its first captured address and channel. Later error events on the same bus leave them unchanged until a subsystem reset command.
- R6: Writing offset 0 with bit 0 set clears the event bit. Writing it with bit 0 clear has no effect. The halt is not affected by either write. If an error event arrives in the same cycle as the clear, the event bit stays set.
- R7: `irq` is high exactly when the event bit is set and bit 0 of the enable register (offset 1) is set.
- R8: Writing offset 6 with bit 0 set is the subsystem reset command. One cycle later the halt, the event bit and both capture pairs are zero, while the enable register keeps its value. Writing offset 6 with bit 0 clear has no effect.
- R9: A reset command in the same cycle as an error event wins: nothing is captured and the halt stays low.
- R10: Error events on both buses in the same cycle capture both pairs independently.
- R11: Offsets 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_done | input | 1 | Main-bus DMA transaction completes this cycle |
| main_err | input | 1 | Main-bus transaction ended with an error |
| main_addr | input | 32 | Main-bus transaction address |
| main_chan | input | 5 | Main-bus requesting channel number |
| loc_done | input | 1 | Local-bus DMA transaction completes this cycle |
| loc_err | input | 1 | Local-bus transaction ended with an error |
| loc_addr | input | 32 | Local-bus transaction address |
| loc_chan | input | 5 | Local-bus requesting channel number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| irq | output | 1 | Error interrupt |
| halt | output | 1 | Communications subsystem freeze |

## Verification
The hardest situations to reach are the same-cycle collisions. One is an error event landing in the very cycle of a reset command. Another is an error event landing in the cycle of an event-bit clear. A third is a second error arriving while the first capture is still held. The bench drives the bus strobes and the register write in the same cycle to force each collision, then reads back every register before the next stimulus. It also sweeps all 32 channel numbers with simultaneous errors on both buses, each followed by a reset command, so both capture paths see every channel field value.

// File: rtl/dmaerr_pkg.sv
package dmaerr_pkg;
  localparam int NBUS     = 2;
  localparam int BUS_MAIN = 0;
  localparam int BUS_LOC  = 1;

  localparam logic [2:0] OFS_STAT  = 3'd0;
  localparam logic [2:0] OFS_EN    = 3'd1;
  localparam logic [2:0] OFS_MADDR = 3'd2;
  localparam logic [2:0] OFS_MCHAN = 3'd3;
  localparam logic [2:0] OFS_LADDR = 3'd4;
  localparam logic [2:0] OFS_LCHAN = 3'd5;
  localparam logic [2:0] OFS_CMD   = 3'd6;

  // a bus fault is a completed transaction flagged as failed
  function automatic logic f_fault(input logic done, input logic err);
    return done & err;
  endfunction

  function automatic logic f_irq(input logic evt, input logic en);
    return evt & en;
  endfunction

  // event bit next state: wipe beats set, set beats clear
  function automatic logic f_evt_next(input logic cur, input logic wipe,
                                      input logic set, input logic clr);
    if (wipe)      return 1'b0;
    else if (set)  return 1'b1;
    else if (clr)  return 1'b0;
    else           return cur;
  endfunction
endpackage

// File: rtl/dmaerr_slot.sv
module dmaerr_slot #(
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          wipe,
  input  logic [DW-1:0] addr_in,
  input  logic [CW-1:0] chan_in,
  output logic          valid,
  output logic [DW-1:0] addr_q,
  output logic [CW-1:0] chan_q
);
  logic take;
  assign take = hit & ~valid & ~wipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr_q <= '0;
      chan_q <= '0;
    end else if (wipe) begin
      valid  <= 1'b0;
      addr_q <= '0;
      chan_q <= '0;
    end else if (take) begin
      valid  <= 1'b1;
      addr_q <= addr_in;
      chan_q <= chan_in;
    end
  end
endmodule

// File: rtl/dmaerr_ctl.sv
module dmaerr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_fault,
  input  logic wipe,
  input  logic clr_evt,
  input  logic en_wr,
  input  logic en_wbit,
  output logic evt,
  output logic halt_q,
  output logic en
);
  import dmaerr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt    <= 1'b0;
      halt_q <= 1'b0;
      en     <= 1'b0;
    end else begin
      evt <= f_evt_next(evt, wipe, any_fault, clr_evt);
      if (wipe)           halt_q <= 1'b0;
      else if (any_fault) halt_q <= 1'b1;
      if (en_wr)          en     <= en_wbit;
    end
  end
endmodule

// File: rtl/dmaerr_rdmux.sv
module dmaerr_rdmux #(
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic [2:0]    ofs,
  input  logic          evt,
  input  logic          halt_q,
  input  logic          en,
  input  logic [DW-1:0] maddr,
  input  logic [CW-1:0] mchan,
  input  logic [DW-1:0] laddr,
  input  logic [CW-1:0] lchan,
  output logic [DW-1:0] rdata
);
  import dmaerr_pkg::*;
  localparam int PAD_CH = DW - CW;

  always_comb begin
    rdata = '0;
    unique case (ofs)
      OFS_STAT:  rdata = {{(DW-2){1'b0}}, halt_q, evt};
      OFS_EN:    rdata = {{(DW-1){1'b0}}, en};
      OFS_MADDR: rdata = maddr;
      OFS_MCHAN: rdata = {{PAD_CH{1'b0}}, mchan};
      OFS_LADDR: rdata = laddr;
      OFS_LCHAN: rdata = {{PAD_CH{1'b0}}, lchan};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture #(
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_done,
  input  logic          main_err,
  input  logic [DW-1:0] main_addr,
  input  logic [CW-1:0] main_chan,
  input  logic          loc_done,
  input  logic          loc_err,
  input  logic [DW-1:0] loc_addr,
  input  logic [CW-1:0] loc_chan,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          halt
);
  import dmaerr_pkg::*;

  logic [NBUS-1:0] bus_done, bus_err, fault_hit, slot_valid;
  logic [DW-1:0]   bus_addr [NBUS];
  logic [CW-1:0]   bus_chan [NBUS];
  logic [DW-1:0]   cap_addr [NBUS];
  logic [CW-1:0]   cap_chan [NBUS];

  assign bus_done = {loc_done, main_done};
  assign bus_err  = {loc_err,  main_err};
  assign bus_addr[BUS_MAIN] = main_addr;
  assign bus_addr[BUS_LOC]  = loc_addr;
  assign bus_chan[BUS_MAIN] = main_chan;
  assign bus_chan[BUS_LOC]  = loc_chan;

  // named internal events, observed by the checker
  logic cmd_fire, clr_evt, en_wr, any_fault;
  logic evt, halt_q, en;
  logic unused_wbits;

  assign cmd_fire  = reg_wr & (reg_addr == OFS_CMD)  & reg_wdata[0];
  assign clr_evt   = reg_wr & (reg_addr == OFS_STAT) & reg_wdata[0];
  assign en_wr     = reg_wr & (reg_addr == OFS_EN);
  assign any_fault = |fault_hit & ~cmd_fire;
  assign unused_wbits = ^reg_wdata[DW-1:1];

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    assign fault_hit[b] = f_fault(bus_done[b], bus_err[b]);
    dmaerr_slot #(.DW(DW), .CW(CW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (fault_hit[b]),
      .wipe    (cmd_fire),
      .addr_in (bus_addr[b]),
      .chan_in (bus_chan[b]),
      .valid   (slot_valid[b]),
      .addr_q  (cap_addr[b]),
      .chan_q  (cap_chan[b])
    );
  end

  dmaerr_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_fault (any_fault),
    .wipe      (cmd_fire),
    .clr_evt   (clr_evt),
    .en_wr     (en_wr),
    .en_wbit   (reg_wdata[0]),
    .evt       (evt),
    .halt_q    (halt_q),
    .en        (en)
  );

  dmaerr_rdmux #(.DW(DW), .CW(CW)) u_rd (
    .ofs    (reg_addr),
    .evt    (evt),
    .halt_q (halt_q),
    .en     (en),
    .maddr  (cap_addr[BUS_MAIN]),
    .mchan  (cap_chan[BUS_MAIN]),
    .laddr  (cap_addr[BUS_LOC]),
    .lchan  (cap_chan[BUS_LOC]),
    .rdata  (reg_rdata)
  );

  assign irq  = f_irq(evt, en);
  assign halt = halt_q;
endmodule

// File: rtl/dmaerr_chk.sv
module dmaerr_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    fault_hit,
  input logic          cmd_fire,
  input logic          clr_evt,
  input logic          evt,
  input logic          halt,
  input logic          en,
  input logic          irq,
  input logic [1:0]    slot_valid,
  input logic [DW-1:0] maddr,
  input logic [DW-1:0] laddr
);
  a_r2_fault_sets_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_hit && !cmd_fire) |=> (evt && halt));

  a_r8_cmd_wipes_all: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> (!evt && !halt && slot_valid == 2'b00));

  a_r5_main_held: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid[0] && !cmd_fire) |=> (slot_valid[0] && $stable(maddr)));

  a_r5_loc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid[1] && !cmd_fire) |=> (slot_valid[1] && $stable(laddr)));

  a_r6_halt_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cmd_fire) |=> halt);

  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && fault_hit == 2'b00 && !cmd_fire) |=> !evt);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt && en));
endmodule

bind dma_err_capture dmaerr_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_hit  (fault_hit),
  .cmd_fire   (cmd_fire),
  .clr_evt    (clr_evt),
  .evt        (evt),
  .halt       (halt_q),
  .en         (en),
  .irq        (irq),
  .slot_valid (slot_valid),
  .maddr      (cap_addr[0]),
  .laddr      (cap_addr[1])
);

// File: tb/sim_dma_err_capture.sv
`timescale 1ns/1ps
module sim_dma_err_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        main_done = 0, main_err = 0, loc_done = 0, loc_err = 0;
  logic [31:0] main_addr = 0, loc_addr = 0;
  logic [4:0]  main_chan = 0, loc_chan = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq, halt;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  dma_err_capture u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] ofs, input logic [31:0] d);
    reg_wr = 1; reg_addr = ofs; reg_wdata = d;
    tick();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] ofs, output logic [31:0] d);
    reg_addr = ofs; #1; d = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] ofs, input logic [31:0] exp);
    logic [31:0] v;
    rd(ofs, v);
    chk(req, v, exp);
  endtask

  task automatic set_main(input logic d, input logic e, input logic [31:0] a, input logic [4:0] c);
    main_done = d; main_err = e; main_addr = a; main_chan = c;
  endtask

  task automatic set_loc(input logic d, input logic e, input logic [31:0] a, input logic [4:0] c);
    loc_done = d; loc_err = e; loc_addr = a; loc_chan = c;
  endtask

  task automatic idle_bus();
    set_main(0, 0, 0, 0); set_loc(0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] maddr_of(input int ch);
    return 32'h8000_0000 + 32'(ch) * 32'h0000_1044;
  endfunction

  function automatic logic [31:0] laddr_of(input int ch);
    return ~maddr_of(ch) ^ 32'(ch << 3);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R1 reset state, R11 unmapped offsets
    for (int o = 0; o < 8; o++) expect_reg("R1/R11 reset read", 3'(o), 32'd0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 halt", {31'd0, halt}, 0);

    // R2 single strobes do nothing
    set_main(1, 0, 32'h1111_0000, 5'd3); set_loc(0, 1, 32'h2222_0000, 5'd4);
    tick(); idle_bus();
    expect_reg("R2 done-only/err-only status", 0, 0);
    set_main(0, 1, 32'h1111_0000, 5'd3); set_loc(1, 0, 32'h2222_0000, 5'd4);
    tick(); idle_bus();
    expect_reg("R2 swapped strobes status", 0, 0);
    chk("R2 halt low", {31'd0, halt}, 0);

    wr(1, 32'h1);
    expect_reg("R7 enable readback", 1, 1);

    // R3 main fault capture, R2 status, R7 irq
    set_main(1, 1, 32'hDEAD_BEEF, 5'd17);
    tick(); idle_bus();
    expect_reg("R2 status after fault", 0, 32'h3);
    chk("R2 halt", {31'd0, halt}, 1);
    chk("R7 irq on", {31'd0, irq}, 1);
    expect_reg("R3 main addr", 2, 32'hDEAD_BEEF);
    expect_reg("R3 main chan", 3, 32'd17);
    expect_reg("R4 loc addr untouched", 4, 0);

    // R5 second main fault ignored
    set_main(1, 1, 32'h0BAD_F00D, 5'd2);
    tick(); idle_bus();
    expect_reg("R5 main addr held", 2, 32'hDEAD_BEEF);
    expect_reg("R5 main chan held", 3, 32'd17);

    // R4 local fault while halted
    set_loc(1, 1, 32'h4000_0ABC, 5'd31);
    tick(); idle_bus();
    expect_reg("R4 loc addr", 4, 32'h4000_0ABC);
    expect_reg("R4 loc chan", 5, 32'd31);
    set_loc(1, 1, 32'h5555_5555, 5'd1);
    tick(); idle_bus();
    expect_reg("R5 loc addr held", 4, 32'h4000_0ABC);

    // R6 clear semantics
    wr(0, 32'hFFFF_FFFE);
    expect_reg("R6 write zero bit no effect", 0, 32'h3);
    wr(0, 32'h1);
    expect_reg("R6 clear leaves halt", 0, 32'h2);
    chk("R6 halt stays", {31'd0, halt}, 1);
    chk("R7 irq off after clear", {31'd0, irq}, 0);

    // R6 set beats clear in same cycle
    set_main(1, 1, 32'h1234_5678, 5'd9);
    reg_wr = 1; reg_addr = 0; reg_wdata = 1;
    tick(); reg_wr = 0; reg_wdata = 0; idle_bus();
    expect_reg("R6 set wins over clear", 0, 32'h3);

    // R7 enable masks irq
    wr(1, 32'h0);
    chk("R7 irq masked", {31'd0, irq}, 0);
    wr(1, 32'h1);
    chk("R7 irq unmasked", {31'd0, irq}, 1);

    // R8 cmd write with bit0 clear does nothing
    wr(6, 32'hFFFF_FFFE);
    chk("R8 zero cmd keeps halt", {31'd0, halt}, 1);
    expect_reg("R8 zero cmd keeps capture", 2, 32'hDEAD_BEEF);
    // R8 real command
    wr(6, 32'h1);
    chk("R8 halt cleared", {31'd0, halt}, 0);
    chk("R8 irq cleared", {31'd0, irq}, 0);
    for (int o = 0; o < 8; o++)
      expect_reg("R8 regs after cmd", 3'(o), (o == 1) ? 32'd1 : 32'd0);

    // R9 command beats a same-cycle fault
    set_main(1, 1, 32'hCAFE_0000, 5'd5); set_loc(1, 1, 32'hCAFE_1111, 5'd6);
    reg_wr = 1; reg_addr = 6; reg_wdata = 1;
    tick(); reg_wr = 0; reg_wdata = 0; idle_bus();
    chk("R9 halt low", {31'd0, halt}, 0);
    expect_reg("R9 status", 0, 0);
    expect_reg("R9 main addr", 2, 0);
    expect_reg("R9 loc addr", 4, 0);

    // R10 sweep all channels with simultaneous faults
    for (int ch = 0; ch < 32; ch++) begin
      set_main(1, 1, maddr_of(ch), 5'(ch));
      set_loc(1, 1, laddr_of(ch), 5'(31 - ch));
      tick(); idle_bus();
      expect_reg("R10 main addr", 2, maddr_of(ch));
      expect_reg("R10 main chan", 3, 32'(ch));
      expect_reg("R10 loc addr", 4, laddr_of(ch));
      expect_reg("R10 loc chan", 5, 32'(31 - ch));
      expect_reg("R10 status", 0, 32'h3);
      wr(6, 32'h1);
      expect_reg("R8 wipe in sweep", 5, 0);
    end

    done_flag = 1;
    summary();
  end
endmodule